// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block performs one shift or rotate per request on a byte, word or long operand and produces the sized result together with five condition flags. The flags are extend (X), negative (N), zero (Z), overflow (V) and carry (C). It covers four families, each in both directions: arithmetic shift, logical shift, plain rotate, and rotate through the extend bit. The surrounding execution pipeline supplies the operand, the operation fields, the shift count and the current extend flag. One cycle later it takes the registered result and flags.

The count can come from three places. The first is a 3-bit immediate field that encodes 1 to 8. The second is the low six bits of a count register, which gives a count taken modulo 64. The third is a single-bit memory form, which always works on a word with a count of one. Bits of the operand above the selected size are passed through untouched.

Top module: `shift_rot_unit`

## Requirements
- R1: Outputs are registered. A request taken with `in_valid` high appears on the outputs at the next rising edge, with `out_valid` high for that one cycle. Without a request the outputs hold their values. A synchronous active-low reset clears every output to zero.
- R2: `size` selects the operand width: 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 or 3 = long (all 32 bits). Result bits above the selected width equal the operand bits.
- R3: `cnt_src` selects the count. 0 = immediate, where `cnt_field` 1..7 means that count and 0 means 8. 1 or 3 = register, where `count_reg` (the count register modulo 64) is the count. 2 = single-bit memory form, with count 1 at word size, ignoring `size` and `cnt_field`.
- R4: `op` selects the family: 0 = arithmetic, 1 = logical, 2 = rotate, 3 = rotate through extend. `dir_left` = 1 shifts toward the MSB and 0 shifts toward bit 0.
- R5: An arithmetic left shift fills with zeros. C and X take the last bit shifted out. V is set when the sized MSB differs from its original value after any step of the shift.
- R6: An arithmetic right shift replicates the MSB of the selected size, not bit 31. C and X take the last bit shifted out, and V is cleared.
- R7: Logical shifts fill with zeros in both directions. C and X take the last bit shifted out, and V is cleared.
- R8: A plain rotate leaves X equal to the incoming extend flag. C takes the last bit rotated out, and V is cleared.
- R9: A rotate through extend treats X as an extra bit of the ring, which is one bit wider than the operand. C and X both end as the last bit rotated out, and V is cleared.
- R10: N equals the MSB of the sized result. Z is set exactly when every bit of the sized result is zero.
- R11: A count of zero leaves the result equal to the operand and X equal to the incoming extend flag, and clears V. C is cleared, except for rotate through extend, where C equals the incoming extend flag.
- R12: Counts larger than the operand width are carried out step by step. A logical shift of a byte by 9 yields zero with C clear, and a 33-step extended rotation of a long returns the operand and X unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Value to shift or rotate |
| size | input | 2 | Operand width code |
| op | input | 2 | Shift family code |
| dir_left | input | 1 | 1 = left, 0 = right |
| cnt_src | input | 2 | Count source select |
| cnt_field | input | 3 | Immediate count field |
| count_reg | input | 6 | Count register, low six bits |
| x_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Sized result with upper bits passed through |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| c_out | output | 1 | New carry flag |

## Verification
The bench builds the unit with its defaults: a 32-bit data path, which gives 8-bit and 16-bit sub-sizes, and a 6-bit count. Register counts up to 63 are therefore in reach. That lets the vectors exercise shifts far past the byte width, a 33-step extended rotation that closes the ring, and a count of 64 that wraps to zero. The narrow sizes make the sign replication of a word and the pass-through of the upper bits visible against a 32-bit operand.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the shift and rotate unit.
// Assumes the operation, size and count-source codes listed in the brief.
package srx_pkg;

    typedef enum logic [1:0] {
        OP_ASH = 2'd0,
        OP_LSH = 2'd1,
        OP_ROT = 2'd2,
        OP_ROX = 2'd3
    } srx_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } srx_size_e;

    typedef enum logic [1:0] {
        CS_IMM     = 2'd0,
        CS_REG     = 2'd1,
        CS_MEM     = 2'd2,
        CS_REG_ALT = 2'd3
    } srx_src_e;

    localparam int IMM_W = 3;

endpackage

// File: rtl/srx_count_sel.sv
`timescale 1ns/1ps
// Resolves the effective shift count and operand size from the count source.
// Assumes CNT_W >= 4 so that the immediate value 8 fits.
module srx_count_sel
    import srx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  srx_src_e                 src,
    input  srx_size_e                size_in,
    input  logic [IMM_W-1:0]         field,
    input  logic [CNT_W-1:0]         reg_cnt,
    output logic [CNT_W-1:0]         cnt,
    output srx_size_e                size_eff
);

    localparam logic [CNT_W-1:0] IMM_MAX = CNT_W'(1 << IMM_W);

    // Choose the count and size for the selected count source.
    always_comb begin
        case (src)
            CS_MEM: begin
                cnt      = CNT_W'(1);
                size_eff = SZ_WORD;
            end
            CS_IMM: begin
                cnt      = (field == '0) ? IMM_MAX : CNT_W'(field);
                size_eff = size_in;
            end
            default: begin
                cnt      = reg_cnt;
                size_eff = size_in;
            end
        endcase
    end

    // Guard that immediate and memory forms never yield a zero or oversize count.
    always_comb begin
        // R3
        imm_range_chk: assert (src == CS_REG || src == CS_REG_ALT ||
                               (cnt >= CNT_W'(1) && cnt <= IMM_MAX));
    end

endmodule

// File: rtl/srx_core.sv
`timescale 1ns/1ps
// Single-size shift and rotate datapath, built as an unrolled chain of
// one-bit steps so each family's extend, carry and overflow rule is
// applied per step. Assumes W >= 2 and a count below 2**CNT_W.
module srx_core
    import srx_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]      opnd,
    input  srx_op_e           op,
    input  logic              left,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              x_in,
    output logic [W-1:0]      res,
    output logic              x_o,
    output logic              c_o,
    output logic              v_o
);

    localparam int MAX_STEPS = (1 << CNT_W) - 1;

    // Walk the requested number of one-bit steps and track the flags.
    always_comb begin
        logic [W-1:0] val;
        logic         xb;
        logic         cb;
        logic         vb;
        logic         out_b;
        logic         sign0;
        val   = opnd;
        xb    = x_in;
        cb    = (op == OP_ROX) ? x_in : 1'b0;
        vb    = 1'b0;
        out_b = 1'b0;
        sign0 = opnd[W-1];
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (i < int'(cnt)) begin
                if (left) begin
                    out_b = val[W-1];
                    case (op)
                        OP_ROT:  val = {val[W-2:0], out_b};
                        OP_ROX:  val = {val[W-2:0], xb};
                        default: val = {val[W-2:0], 1'b0};
                    endcase
                end else begin
                    out_b = val[0];
                    case (op)
                        OP_ASH:  val = {val[W-1], val[W-1:1]};
                        OP_LSH:  val = {1'b0, val[W-1:1]};
                        OP_ROT:  val = {out_b, val[W-1:1]};
                        default: val = {xb, val[W-1:1]};
                    endcase
                end
                cb = out_b;
                if (op != OP_ROT) begin
                    xb = out_b;
                end
                if (op == OP_ASH && left && (val[W-1] != sign0)) begin
                    vb = 1'b1;
                end
            end
        end
        res = val;
        x_o = xb;
        c_o = cb;
        v_o = vb;
    end

    // Guard that only an arithmetic left shift can report overflow.
    always_comb begin
        // R7
        core_v_chk: assert (!v_o || (op == OP_ASH && left));
    end

endmodule

// File: rtl/shift_rot_unit.sv
`timescale 1ns/1ps
// Shift and rotate unit with condition flags. One datapath per operand
// size is generated, the effective size picks one, and the sized result
// and flags are registered. Assumes DATA_W is a multiple of 4.
module shift_rot_unit
    import srx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    operand,
    input  logic [1:0]           size,
    input  logic [1:0]           op,
    input  logic                 dir_left,
    input  logic [1:0]           cnt_src,
    input  logic [IMM_W-1:0]     cnt_field,
    input  logic [CNT_W-1:0]     count_reg,
    input  logic                 x_in,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic                 x_out,
    output logic                 n_out,
    output logic                 z_out,
    output logic                 v_out,
    output logic                 c_out
);

    localparam int NUM_SZ = 3;

    srx_op_e            op_e;
    srx_size_e          size_eff;
    logic [CNT_W-1:0]   cnt;
    logic [1:0]         sel;

    logic [DATA_W-1:0]  sz_res [NUM_SZ];
    logic               sz_x   [NUM_SZ];
    logic               sz_c   [NUM_SZ];
    logic               sz_v   [NUM_SZ];
    logic               sz_n   [NUM_SZ];
    logic               sz_z   [NUM_SZ];

    assign op_e = srx_op_e'(op);

    srx_count_sel #(.CNT_W(CNT_W)) cnt_sel_i (
        .src      (srx_src_e'(cnt_src)),
        .size_in  (srx_size_e'(size)),
        .field    (cnt_field),
        .reg_cnt  (count_reg),
        .cnt      (cnt),
        .size_eff (size_eff)
    );

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
        localparam int W = DATA_W >> (2 - k);
        logic [W-1:0] r;

        srx_core #(.W(W), .CNT_W(CNT_W)) core_i (
            .opnd (operand[W-1:0]),
            .op   (op_e),
            .left (dir_left),
            .cnt  (cnt),
            .x_in (x_in),
            .res  (r),
            .x_o  (sz_x[k]),
            .c_o  (sz_c[k]),
            .v_o  (sz_v[k])
        );

        if (W < DATA_W) begin : g_part
            assign sz_res[k] = {operand[DATA_W-1:W], r};
        end else begin : g_full
            assign sz_res[k] = r;
        end
        assign sz_n[k] = r[W-1];
        assign sz_z[k] = (r == '0);
    end

    // Map the effective size code onto a datapath index.
    always_comb begin
        case (size_eff)
            SZ_BYTE: sel = 2'd0;
            SZ_WORD: sel = 2'd1;
            default: sel = 2'd2;
        endcase
    end

    // Register the selected result and flags when a request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            x_out     <= 1'b0;
            n_out     <= 1'b0;
            z_out     <= 1'b0;
            v_out     <= 1'b0;
            c_out     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sz_res[sel];
                x_out  <= sz_x[sel];
                n_out  <= sz_n[sel];
                z_out  <= sz_z[sel];
                v_out  <= sz_v[sel];
                c_out  <= sz_c[sel];
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R8
    rot_x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROT) |=> (x_out == $past(x_in)));

    // R9
    rox_cx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROX) |=> (c_out == x_out));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(op == OP_ASH && dir_left)) |=> !v_out);

    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_src != CS_MEM && size == SZ_BYTE)
        |=> (result[DATA_W-1:DATA_W/4] == $past(operand[DATA_W-1:DATA_W/4])));

    // R11
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_src == CS_REG && count_reg == '0)
        |=> (result == $past(operand) && x_out == $past(x_in) && !v_out));

endmodule

// File: tb/shift_rot_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = '0;
    logic [1:0]  op = '0;
    logic        dir_left = 1'b0;
    logic [1:0]  cnt_src = '0;
    logic [2:0]  cnt_field = '0;
    logic [5:0]  count_reg = '0;
    logic        x_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        x_out, n_out, z_out, v_out, c_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_rot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .size(size), .op(op), .dir_left(dir_left), .cnt_src(cnt_src),
        .cnt_field(cnt_field), .count_reg(count_reg), .x_in(x_in),
        .out_valid(out_valid), .result(result), .x_out(x_out),
        .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
    );

    // Vector: req[89:86] op[85:84] dir[83] size[82:81] src[80:79]
    // field[78:76] creg[75:70] x[69] operand[68:37] result[36:5] xnzvc[4:0]
    localparam int NV = 16;
    localparam logic [89:0] VECS [NV] = '{
        // R5 ASL byte by 1, sign flips
        {4'd5, 2'd0,1'b1,2'd0,2'd0,3'd1,6'd0, 1'b0,32'h12345640,32'h12345680,5'b01010},
        // R5 ASL word, immediate 0 means 8
        {4'd5, 2'd0,1'b1,2'd1,2'd0,3'd0,6'd0, 1'b1,32'hAAAA0181,32'hAAAA8100,5'b11011},
        // R6 ASR byte by register 3
        {4'd6, 2'd0,1'b0,2'd0,2'd1,3'd0,6'd3, 1'b1,32'h7F7F7F90,32'h7F7F7FF2,5'b01000},
        // R6 ASR word uses word sign, not bit 31
        {4'd6, 2'd0,1'b0,2'd1,2'd0,3'd2,6'd0, 1'b0,32'h80004000,32'h80001000,5'b00000},
        // R7 LSR long by 1
        {4'd7, 2'd1,1'b0,2'd2,2'd0,3'd1,6'd0, 1'b0,32'h80000001,32'h40000000,5'b10001},
        // R12 LSL byte by 9 gives zero, C clear
        {4'd12,2'd1,1'b1,2'd0,2'd1,3'd0,6'd9, 1'b1,32'h000000FF,32'h00000000,5'b00100},
        // R8 ROL byte by 1, X kept
        {4'd8, 2'd2,1'b1,2'd0,2'd0,3'd1,6'd0, 1'b0,32'h00000081,32'h00000003,5'b00001},
        // R8 ROR word by register 4
        {4'd8, 2'd2,1'b0,2'd1,2'd1,3'd0,6'd4, 1'b1,32'h1234ABCD,32'h1234DABC,5'b11001},
        // R9 ROXL byte by 1, X enters at bit 0
        {4'd9, 2'd3,1'b1,2'd0,2'd0,3'd1,6'd0, 1'b1,32'h00000080,32'h00000001,5'b10001},
        // R12 ROXR long by 33 closes the ring
        {4'd12,2'd3,1'b0,2'd2,2'd1,3'd0,6'd33,1'b0,32'h00000001,32'h00000001,5'b00000},
        // R11 ROXL count 64 wraps to 0, C = X
        {4'd11,2'd3,1'b1,2'd2,2'd1,3'd0,6'd0, 1'b1,32'h00000000,32'h00000000,5'b10101},
        // R11 LSL word count 0 clears C, X kept
        {4'd11,2'd1,1'b1,2'd1,2'd1,3'd0,6'd0, 1'b1,32'h00008000,32'h00008000,5'b11000},
        // R3 memory form forces word and count 1
        {4'd3, 2'd0,1'b1,2'd0,2'd2,3'd5,6'd0, 1'b0,32'h0000C000,32'h00008000,5'b11001},
        // R5 ASL long by 2, late sign change
        {4'd5, 2'd0,1'b1,2'd2,2'd1,3'd0,6'd2, 1'b0,32'hC0000000,32'h00000000,5'b10111},
        // R10 ASR long of all ones
        {4'd10,2'd0,1'b0,2'd2,2'd0,3'd1,6'd0, 1'b0,32'hFFFFFFFF,32'hFFFFFFFF,5'b11001},
        // R2 size code 3 acts as long
        {4'd2, 2'd1,1'b0,2'd3,2'd0,3'd1,6'd0, 1'b1,32'h00000100,32'h00000080,5'b00000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [89:0] v);
        @(negedge clk);
        op        = v[85:84];
        dir_left  = v[83];
        size      = v[82:81];
        cnt_src   = v[80:79];
        cnt_field = v[78:76];
        count_reg = v[75:70];
        x_in      = v[69];
        operand   = v[68:37];
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    function automatic logic [31:0] flg();
        return {27'd0, x_out, n_out, z_out, v_out, c_out};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset flags", flg(), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [89:0] v;
            string tag;
            v = VECS[i];
            send(v);
            tag = $sformatf("R%0d vec%0d", v[89:86], i);
            chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
            chk({tag, " result"}, result, v[36:5]);
            chk({tag, " xnzvc"}, flg(), {27'd0, v[4:0]});
        end

        // R1 no request: valid drops and outputs hold
        @(negedge clk);
        chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R1 idle hold", result, 32'h00000080);

        // R4 same operand, direction flips outcome (LSL long 1 vs LSR)
        send({4'd4,2'd1,1'b1,2'd2,2'd0,3'd1,6'd0,1'b0,32'h00000003,32'd0,5'd0});
        chk("R4 left result", result, 32'h00000006);
        send({4'd4,2'd1,1'b0,2'd2,2'd0,3'd1,6'd0,1'b0,32'h00000003,32'd0,5'd0});
        chk("R4 right result", result, 32'h00000001);
        chk("R4 right carry", {31'd0, c_out}, 32'd1);

        // R1 synchronous reset while a request is presented
        @(negedge clk);
        operand  = 32'hFFFFFFFF;
        op       = 2'd0;
        cnt_src  = 2'd0;
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 reset valid mid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset result mid", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule